// File: doc/BRIEF.md
# SIMD Lane Execution Mask Stack

This block holds the lane-enable mask for a 64-lane vector unit that one scalar controller drives. Bit i of the mask enables vector lane i. The controller resolves structured if/else/endif regions by sending commands to the block. Each opening of a region saves the live mask in a bounded hardware stack and narrows the mask by a per-lane condition vector. The alternative branch enables the complement of the lanes that ran the first branch, but only among the lanes that were enabled when the region was opened. Closing the region restores the saved mask.

A flag reports when no lane is enabled. The sequencer can use it to skip the body of a region. Opening a region when every save slot is in use is an error. Alternating or closing a region when no region is open is also an error. Each error sets its own sticky flag, and the offending command has no other effect.

Top module: `lane_mask_stack`

## Requirements
- R1: After reset, the mask is all ones, the save stack is empty, and the zero, overflow and underflow flags are low.
- R2: A command with code 1 (open) while the stack holds fewer than DEPTH entries pushes the current mask. The next mask is then cond AND current mask, bit i being lane i in both vectors.
- R3: A command with code 2 (alternate) on a non-empty stack sets the mask to (NOT current mask) AND the saved top entry, and leaves the stack depth unchanged.
- R4: A command with code 3 (close) on a non-empty stack pops the top entry and makes it the mask. Saved masks return in last-in first-out order.
- R5: mask_zero is high exactly when every bit of exec_mask is zero.
- R6: Code 1 while the stack holds DEPTH entries sets the sticky overflow flag and leaves the mask and the stack unchanged.
- R7: Code 2 or code 3 on an empty stack sets the sticky underflow flag and leaves the mask and the stack unchanged.
- R8: A cycle with cmd_valid low, or with code 0 (no operation), holds the mask, the stack and both error flags.
- R9: An accepted command takes effect at the clock edge where it is sampled, and its result appears on exec_mask in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Strobe that qualifies cmd in this cycle |
| cmd | input | 2 | 0 no-op, 1 open, 2 alternate, 3 close |
| cond | input | 64 | Per-lane condition, bit i from lane i |
| exec_mask | output | 64 | Current lane-enable mask |
| mask_zero | output | 1 | High when no lane is enabled |
| overflow | output | 1 | Sticky: open attempted with a full stack |
| underflow | output | 1 | Sticky: alternate or close attempted with an empty stack |

## Verification
The checker assumes that cmd_valid, cmd and cond hold known, stable values at every rising edge. It also assumes that cond is ignored whenever the command is not an open. The stimulus changes inputs only at falling edges and drops cmd_valid between directed operations, so every property sees one well-defined command per edge. The checker keeps its own count of the stack depth from accepted opens and closes. The overflow and underflow properties therefore rely on commands being counted exactly as the requirements define them, and the bench holds the default depth so its table of expected masks matches that count.

// File: rtl/lane_mask_pkg.sv
package lane_mask_pkg;

    typedef enum logic [1:0] {
        OP_NOP   = 2'd0,
        OP_OPEN  = 2'd1,
        OP_ALT   = 2'd2,
        OP_CLOSE = 2'd3
    } mask_op_e;

endpackage

// File: rtl/mask_save_stack.sv
module mask_save_stack #(
    parameter int WIDTH = 64,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] push_data,
    output logic [WIDTH-1:0] top_data,
    output logic             full,
    output logic             empty
);
    localparam int PW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [PW-1:0]    sp_d, sp_q;
    logic [IW-1:0]    wr_idx, rd_idx;
    logic [WIDTH-1:0] slot_q [DEPTH];

    assign full   = (sp_q == PW'(DEPTH));
    assign empty  = (sp_q == '0);
    assign wr_idx = IW'(sp_q);
    assign rd_idx = IW'(sp_q - PW'(1));

    always_comb begin
        sp_d = sp_q;
        if (push && !full)
            sp_d = sp_q + PW'(1);
        else if (pop && !empty)
            sp_d = sp_q - PW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            sp_q <= '0;
        else
            sp_q <= sp_d;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && !full && wr_idx == IW'(g))
                slot_q[g] <= push_data;
        end
    end

    assign top_data = empty ? '0 : slot_q[rd_idx];

endmodule

// File: rtl/mask_step_logic.sv
module mask_step_logic
    import lane_mask_pkg::*;
#(
    parameter int LANES = 64
) (
    input  logic             cmd_valid,
    input  logic [1:0]       cmd,
    input  logic [LANES-1:0] cond,
    input  logic [LANES-1:0] mask_cur,
    input  logic [LANES-1:0] saved_top,
    input  logic             stk_full,
    input  logic             stk_empty,
    output logic [LANES-1:0] mask_nxt,
    output logic             do_push,
    output logic             do_pop,
    output logic             ovf_evt,
    output logic             unf_evt
);
    mask_op_e op;

    always_comb begin
        op       = cmd_valid ? mask_op_e'(cmd) : OP_NOP;
        mask_nxt = mask_cur;
        do_push  = 1'b0;
        do_pop   = 1'b0;
        ovf_evt  = 1'b0;
        unf_evt  = 1'b0;
        unique case (op)
            OP_OPEN: begin
                if (stk_full) begin
                    ovf_evt = 1'b1;
                end else begin
                    do_push  = 1'b1;
                    mask_nxt = cond & mask_cur;
                end
            end
            OP_ALT: begin
                if (stk_empty)
                    unf_evt = 1'b1;
                else
                    mask_nxt = ~mask_cur & saved_top;
            end
            OP_CLOSE: begin
                if (stk_empty) begin
                    unf_evt = 1'b1;
                end else begin
                    do_pop   = 1'b1;
                    mask_nxt = saved_top;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/lane_mask_stack.sv
module lane_mask_stack #(
    parameter int LANES = 64,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd,
    input  logic [LANES-1:0] cond,
    output logic [LANES-1:0] exec_mask,
    output logic             mask_zero,
    output logic             overflow,
    output logic             underflow
);
    typedef struct packed {
        logic [LANES-1:0] mask;
        logic             ovf;
        logic             unf;
    } ctl_state_t;

    ctl_state_t       st_d, st_q;
    logic [LANES-1:0] mask_nxt, saved_top;
    logic             do_push, do_pop, ovf_evt, unf_evt;
    logic             stk_full, stk_empty;

    mask_save_stack #(.WIDTH(LANES), .DEPTH(DEPTH)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (do_push),
        .pop       (do_pop),
        .push_data (st_q.mask),
        .top_data  (saved_top),
        .full      (stk_full),
        .empty     (stk_empty)
    );

    mask_step_logic #(.LANES(LANES)) u_step (
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .cond      (cond),
        .mask_cur  (st_q.mask),
        .saved_top (saved_top),
        .stk_full  (stk_full),
        .stk_empty (stk_empty),
        .mask_nxt  (mask_nxt),
        .do_push   (do_push),
        .do_pop    (do_pop),
        .ovf_evt   (ovf_evt),
        .unf_evt   (unf_evt)
    );

    always_comb begin
        st_d      = st_q;
        st_d.mask = mask_nxt;
        if (ovf_evt) st_d.ovf = 1'b1;
        if (unf_evt) st_d.unf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mask <= '1;
            st_q.ovf  <= 1'b0;
            st_q.unf  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign exec_mask = st_q.mask;
    assign mask_zero = ~|st_q.mask;
    assign overflow  = st_q.ovf;
    assign underflow = st_q.unf;

endmodule

// File: rtl/lane_mask_stack_chk.sv
module lane_mask_stack_chk #(
    parameter int LANES = 64,
    parameter int DEPTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [1:0]       cmd,
    input logic [LANES-1:0] cond,
    input logic [LANES-1:0] exec_mask,
    input logic             mask_zero,
    input logic             overflow,
    input logic             underflow
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] ref_depth;
    logic          is_open, is_alt, is_close, ref_full, ref_empty;

    assign is_open   = cmd_valid && cmd == 2'd1;
    assign is_alt    = cmd_valid && cmd == 2'd2;
    assign is_close  = cmd_valid && cmd == 2'd3;
    assign ref_full  = (ref_depth == CW'(DEPTH));
    assign ref_empty = (ref_depth == '0);

    always_ff @(posedge clk) begin
        if (!rst_n)
            ref_depth <= '0;
        else if (is_open && !ref_full)
            ref_depth <= ref_depth + CW'(1);
        else if (is_close && !ref_empty)
            ref_depth <= ref_depth - CW'(1);
    end

    assert_reset_mask_R1: assert property (@(posedge clk)
        !rst_n |=> (&exec_mask) && !overflow && !underflow);

    assert_open_narrows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (is_open && !ref_full) |=> exec_mask == ($past(cond) & $past(exec_mask)));

    assert_zero_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mask_zero == (exec_mask == '0));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_open && ref_full) |=> overflow && $stable(exec_mask));

    assert_overflow_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((is_alt || is_close) && ref_empty) |=> underflow && $stable(exec_mask));

    assert_underflow_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);

    assert_idle_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid || cmd == 2'd0) |=> $stable(exec_mask) && $stable(overflow)
                                        && $stable(underflow));

    assert_alt_subset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_alt && !ref_empty) |=> (exec_mask & $past(exec_mask)) == '0);

endmodule

bind lane_mask_stack lane_mask_stack_chk #(.LANES(LANES), .DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd       (cmd),
    .cond      (cond),
    .exec_mask (exec_mask),
    .mask_zero (mask_zero),
    .overflow  (overflow),
    .underflow (underflow)
);

// File: tb/lane_mask_stack_tb.sv
module lane_mask_stack_tb;
    localparam int LANES = 64;
    localparam int DEPTH = 16;
    localparam logic [63:0] ONES = '1;

    typedef struct packed {
        logic        vld;
        logic [1:0]  cmd;
        logic [63:0] cond;
        logic [63:0] exp;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 2'd1, 64'h0000_0000_FFFF_0000, 64'h0000_0000_FFFF_0000}, // R2
        '{1'b1, 2'd1, 64'h0000_0000_FF00_FF00, 64'h0000_0000_FF00_0000}, // R2
        '{1'b1, 2'd2, 64'h1234_5678_9ABC_DEF0, 64'h0000_0000_00FF_0000}, // R3
        '{1'b1, 2'd3, 64'h0,                   64'h0000_0000_FFFF_0000}, // R4
        '{1'b1, 2'd2, 64'h0,                   64'hFFFF_FFFF_0000_FFFF}, // R3
        '{1'b1, 2'd1, 64'h0,                   64'h0},                   // R2 R5
        '{1'b0, 2'd3, 64'h0,                   64'h0},                   // R8
        '{1'b1, 2'd0, 64'hFFFF,                64'h0},                   // R8
        '{1'b1, 2'd3, 64'h0,                   64'hFFFF_FFFF_0000_FFFF}, // R4
        '{1'b1, 2'd3, 64'h0,                   ONES}                     // R4
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0;
    logic [1:0]       cmd = 2'd0;
    logic [LANES-1:0] cond = '0;
    logic [LANES-1:0] exec_mask;
    logic             mask_zero, overflow, underflow;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    lane_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .cond      (cond),
        .exec_mask (exec_mask),
        .mask_zero (mask_zero),
        .overflow  (overflow),
        .underflow (underflow)
    );

    task automatic check_mask(string req, logic [63:0] exp);
        total++;
        if (exec_mask !== exp) begin
            bad++;
            $display("FAIL %s mask actual=%h expected=%h", req, exec_mask, exp);
        end
        total++;
        if (mask_zero !== (exp == 64'h0)) begin
            bad++;
            $display("FAIL R5 zero flag actual=%b expected=%b", mask_zero, exp == 64'h0);
        end
    endtask

    task automatic check_bit(string req, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s flag actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic step(logic v, logic [1:0] c, logic [63:0] cd);
        cmd_valid = v;
        cmd       = c;
        cond      = cd;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd       = 2'd0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        check_mask("R1", ONES);
        check_bit("R1 overflow", overflow, 1'b0);
        check_bit("R1 underflow", underflow, 1'b0);

        // R9: result visible one cycle after the edge that samples the command
        for (int i = 0; i < NV; i++) begin
            step(TBL[i].vld, TBL[i].cmd, TBL[i].cond);
            check_mask($sformatf("R9 vec%0d", i), TBL[i].exp);
        end
        check_bit("R6 no overflow", overflow, 1'b0);
        check_bit("R7 no underflow", underflow, 1'b0);

        // R7: close and alternate on an empty stack
        step(1'b1, 2'd3, '0);
        check_bit("R7 close empty", underflow, 1'b1);
        check_mask("R7 close empty", ONES);
        step(1'b1, 2'd2, '0);
        check_mask("R7 alt empty", ONES);
        step(1'b0, 2'd0, '0);
        check_bit("R7 sticky", underflow, 1'b1);
        // R7: stack untouched, an open then close still restores all ones
        step(1'b1, 2'd1, 64'h5);
        check_mask("R2 after underflow", 64'h5);
        step(1'b1, 2'd3, '0);
        check_mask("R4 after underflow", ONES);

        // R6 and R4: fill the stack with distinct masks
        do_reset();
        for (int k = 0; k < DEPTH; k++) begin
            step(1'b1, 2'd1, ~(64'h1 << k));
            check_mask("R2 fill", ~((64'h1 << (k + 1)) - 64'h1));
        end
        check_bit("R6 full no error", overflow, 1'b0);
        step(1'b1, 2'd1, 64'h0);
        check_bit("R6 overflow", overflow, 1'b1);
        check_mask("R6 mask kept", ~((64'h1 << DEPTH) - 64'h1));
        for (int j = 1; j <= DEPTH; j++) begin
            step(1'b1, 2'd3, '0);
            check_mask("R4 lifo", ~((64'h1 << (DEPTH - j)) - 64'h1));
        end
        check_bit("R6 sticky", overflow, 1'b1);
        check_bit("R7 no underflow", underflow, 1'b0);

        // R8: invalid strobe with an open command has no effect
        step(1'b0, 2'd1, 64'h0);
        check_mask("R8 no valid", ONES);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R9 watchdog actual=timeout expected=complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule